// File: doc/BRIEF.md
# Receive Frame FIFO with Runt Discard and Pad Trimming

This block is a 256-byte, byte-wide elastic store between a MAC receive byte stream and a bus-master DMA reader. The write side delivers bytes tagged with start and end markers. The block keeps a per-frame status record. It cancels short collision fragments by moving the write pointer back to the start of the frame, so the reader never sees any part of such a fragment. For 802.3 frames whose type/length field holds a small length, it can also trim the padding and everything after it.

The read side is a valid/ready byte stream. It carries first-byte and last-byte markers, and a status word that is valid on the last byte. A request line tells the DMA engine when to start draining. It rises when the readable byte count reaches a level chosen by a 2-bit code, or when a complete frame is waiting. Configuration logic is expected to present code 01 (64 bytes) after a hard reset.

A frame becomes readable once it has been committed at its end. Frames of 64 bytes or more become readable earlier: once 64 bytes have been received, all written bytes except the newest one can be read. The newest byte is held back because the block cannot yet tell whether it is the last.

Top module: `rx_frame_fifo`

## Requirements
- R1: After reset `rdValid` and `dmaReq` are low and the store is empty.
- R2: A frame of 64 or more received bytes is delivered byte-exact and in order. `rdSof` is high on its first byte and `rdEof` on its last. On the last byte, `rdStatus[13:3]` holds the delivered length and `rdStatus[2:0]` is zero when nothing was dropped.
- R3: With `acceptRunt` low, a frame of fewer than 64 received bytes (63 included) leaves no byte and no status behind. The following frame is delivered intact.
- R4: With `acceptRunt` high, a frame of fewer than 64 bytes is delivered, and its status has bit 1 (runt flag) set.
- R5: `dmaReq` is high when the readable byte count is at least the watermark level, or when at least one complete frame status is queued. The `wmCode` levels are 00=16, 01=64, 10=128, 11=128.
- R6: With `stripEn` high, frame bytes 12 (high) and 13 (low) are read as a big-endian value L. When L is 46 or less, only the first 14+L bytes are delivered, and status bit 0 (trimmed flag) is set.
- R7: When L is above 46, including type values of 0x0600 and above, the frame is delivered whole and bit 0 stays clear, even with `stripEn` high.
- R8: When 256 bytes are held, further bytes of the frame are dropped. The frame's status then has bit 2 (overflow flag) set and a length equal to the bytes actually stored.
- R9: Once 64 bytes of an open frame have been received, all its written bytes except the newest can be read before the end marker arrives.
- R10: With `STAT_DEPTH` (8) frame statuses queued, a frame that starts is discarded in full.
- R11: While `rdValid` is high and `rdReady` is low, `rdValid` stays high and `rdData` is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Write byte strobe |
| wrData | input | 8 | Write byte |
| wrSof | input | 1 | Byte is the first of a frame |
| wrEof | input | 1 | Byte is the last of a frame |
| acceptRunt | input | 1 | Test mode: keep frames shorter than 64 bytes |
| stripEn | input | 1 | Enable pad trimming by length field |
| wmCode | input | 2 | Watermark level code |
| rdReady | input | 1 | Reader takes the presented byte |
| rdValid | output | 1 | A byte is presented |
| rdData | output | 8 | Presented byte |
| rdSof | output | 1 | Presented byte is the first of its frame |
| rdEof | output | 1 | Presented byte is the last of its frame |
| rdStatus | output | 14 | {length[10:0], overflow, runt, trimmed}; valid with rdEof |
| dmaReq | output | 1 | DMA drain request |

## Verification
A rollback pointer left at the wrong place shows up at once: the next delivered frame starts with stale fragment bytes, or the status length disagrees with the count of bytes between `rdSof` and `rdEof`. A fault in the early-read limit shows up within a cycle of the 64th byte, as `dmaReq` or `rdValid` changing at the wrong count. It can also make `rdEof` be missed at the end of a long frame. Trimming and overflow faults show up only in the status word and the length of the frame concerned, so each case is read back in full.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int LEN_W = 11;
  localparam int CNT_W = 16;
  localparam int ST_W  = LEN_W + 3;

  typedef struct packed {
    logic wrEn;      // store the current byte
    logic rollback;  // cancel the open frame
    logic commit;    // close the frame and queue its status
    logic spill;     // open frame is past the runt limit
    logic ovf;
    logic runt;
    logic strip;
  } rxf_strobe_t;

  function automatic int unsigned wmLevel(input logic [1:0] code);
    case (code)
      2'b00:   return 16;
      2'b01:   return 64;
      default: return 128;
    endcase
  endfunction
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int MIN_FRAME = 64,
  parameter int HDR_BYTES = 14,
  parameter int MAX_PAD_LEN = 46
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [7:0]       wrData,
  input  logic             wrSof,
  input  logic             wrEof,
  input  logic             acceptRunt,
  input  logic             stripEn,
  input  logic             fifoFull,
  input  logic             statFull,
  output rxf_strobe_t      stb,
  output logic [LEN_W-1:0] frameLen
);
  localparam int LEN_HI_IDX = HDR_BYTES - 2;
  localparam int LEN_LO_IDX = HDR_BYTES - 1;

  logic             open, drop, ovf, stripped, stripOn;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] stored, keepLen;
  logic [7:0]       lenHi;

  logic             active, dropNow, keep, store, ovfAll, removed, isRunt, ending, discard;
  logic [CNT_W-1:0] idx, nextCnt;
  logic [LEN_W-1:0] storedNext;
  logic [15:0]      lenVal;

  always_comb begin
    active     = wrValid && (wrSof || open);
    idx        = wrSof ? '0 : cnt;
    nextCnt    = (idx == {CNT_W{1'b1}}) ? idx : idx + 1'b1;
    dropNow    = wrSof ? statFull : drop;
    keep       = !(stripOn && !wrSof && (idx >= CNT_W'(keepLen)));
    store      = active && keep && !dropNow && !fifoFull;
    ovfAll     = (wrSof ? 1'b0 : ovf) | (active && keep && !dropNow && fifoFull);
    removed    = (wrSof ? 1'b0 : stripped) | (active && !keep);
    storedNext = (wrSof ? '0 : stored) + LEN_W'(store);
    isRunt     = nextCnt < CNT_W'(MIN_FRAME);
    ending     = active && wrEof;
    discard    = dropNow || (isRunt && !acceptRunt) || (storedNext == '0);
    lenVal     = {lenHi, wrData};

    stb.wrEn     = store;
    stb.rollback = ending && discard;
    stb.commit   = ending && !discard;
    stb.spill    = open && !drop && (cnt >= CNT_W'(MIN_FRAME));
    stb.ovf      = ovfAll;
    stb.runt     = isRunt;
    stb.strip    = removed;
    frameLen     = storedNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      open     <= 1'b0;
      drop     <= 1'b0;
      ovf      <= 1'b0;
      stripped <= 1'b0;
      stripOn  <= 1'b0;
      cnt      <= '0;
      stored   <= '0;
      keepLen  <= '0;
      lenHi    <= '0;
    end else if (active) begin
      open     <= !wrEof;
      drop     <= dropNow;
      ovf      <= ovfAll;
      stripped <= removed;
      cnt      <= nextCnt;
      stored   <= storedNext;
      if (wrSof) stripOn <= 1'b0;
      if (idx == CNT_W'(LEN_HI_IDX)) lenHi <= wrData;
      if (idx == CNT_W'(LEN_LO_IDX)) begin
        stripOn <= stripEn && (lenVal <= 16'(MAX_PAD_LEN));
        keepLen <= LEN_W'(HDR_BYTES) + LEN_W'(lenVal[7:0]);
      end
    end
  end
endmodule

// File: rtl/rxf_dp.sv
module rxf_dp
  import rxf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int STAT_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxf_strobe_t      stb,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [7:0]       wrData,
  input  logic [1:0]       wmCode,
  input  logic             rdReady,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             rdSof,
  output logic             rdEof,
  output logic [ST_W-1:0]  rdStatus,
  output logic             dmaReq,
  output logic             fifoFull,
  output logic             statFull
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int SA_W   = $clog2(STAT_DEPTH);
  localparam int SP_W   = SA_W + 1;

  logic [7:0]      mem [DEPTH];
  logic [ST_W-1:0] stq [STAT_DEPTH];

  logic [PTR_W-1:0] wrPtr, startPtr, rdPtr, readLimit, avail, fill;
  logic [SP_W-1:0]  stWr, stRd, statCount;
  logic [LEN_W-1:0] rdCount, headLen;
  logic [ST_W-1:0]  head;
  logic             statAny, pop;

  always_comb begin
    readLimit = (stb.spill && (wrPtr != startPtr)) ? wrPtr - 1'b1 : startPtr;
    avail     = readLimit - rdPtr;
    fill      = wrPtr - rdPtr;
    fifoFull  = fill == PTR_W'(DEPTH);
    statCount = stWr - stRd;
    statFull  = statCount == SP_W'(STAT_DEPTH);
    statAny   = statCount != '0;
    head      = stq[stRd[SA_W-1:0]];
    headLen   = head[ST_W-1:3];
    rdValid   = avail != '0;
    rdData    = mem[rdPtr[ADDR_W-1:0]];
    rdSof     = rdValid && (rdCount == '0);
    rdEof     = rdValid && statAny && ((rdCount + 1'b1) == headLen);
    rdStatus  = head;
    pop       = rdValid && rdReady;
    dmaReq    = (avail >= PTR_W'(wmLevel(wmCode))) || statAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      startPtr <= '0;
      rdPtr    <= '0;
      rdCount  <= '0;
      stWr     <= '0;
      stRd     <= '0;
    end else begin
      if (stb.rollback)  wrPtr <= startPtr;
      else if (stb.wrEn) wrPtr <= wrPtr + 1'b1;
      if (stb.commit) begin
        startPtr <= wrPtr + PTR_W'(stb.wrEn);
        stWr     <= stWr + 1'b1;
      end
      if (pop) begin
        rdPtr <= rdPtr + 1'b1;
        if (rdEof) begin
          rdCount <= '0;
          stRd    <= stRd + 1'b1;
        end else begin
          rdCount <= rdCount + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn)   mem[wrPtr[ADDR_W-1:0]] <= wrData;
    if (stb.commit) stq[stWr[SA_W-1:0]]    <= {frameLen, stb.ovf, stb.runt, stb.strip};
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN) fill <= PTR_W'(DEPTH)); // R8
  AST_ROLLBACK_RESTORE: assert property (@(posedge clk) disable iff (!rstN) stb.rollback |=> wrPtr == $past(startPtr)); // R3
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN) rdValid && !rdReady |=> rdValid && $stable(rdData)); // R11
  AST_SOF_AFTER_EOF: assert property (@(posedge clk) disable iff (!rstN) rdValid && rdReady && rdEof |=> rdCount == '0); // R2
  AST_STATQ_BOUND: assert property (@(posedge clk) disable iff (!rstN) statCount <= SP_W'(STAT_DEPTH)); // R10
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int STAT_DEPTH = 8,
  parameter int MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [7:0]       wrData,
  input  logic             wrSof,
  input  logic             wrEof,
  input  logic             acceptRunt,
  input  logic             stripEn,
  input  logic [1:0]       wmCode,
  input  logic             rdReady,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             rdSof,
  output logic             rdEof,
  output logic [ST_W-1:0]  rdStatus,
  output logic             dmaReq
);
  rxf_strobe_t      stb;
  logic [LEN_W-1:0] frameLen;
  logic             fifoFull, statFull;

  rxf_ctrl #(.MIN_FRAME(MIN_FRAME)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .wrSof(wrSof), .wrEof(wrEof), .acceptRunt(acceptRunt), .stripEn(stripEn),
    .fifoFull(fifoFull), .statFull(statFull), .stb(stb), .frameLen(frameLen)
  );

  rxf_dp #(.DEPTH(DEPTH), .STAT_DEPTH(STAT_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .frameLen(frameLen), .wrData(wrData),
    .wmCode(wmCode), .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData),
    .rdSof(rdSof), .rdEof(rdEof), .rdStatus(rdStatus), .dmaReq(dmaReq),
    .fifoFull(fifoFull), .statFull(statFull)
  );
endmodule

// File: tb/rx_frame_fifo_tb_top.sv
module rx_frame_fifo_tb_top;
  logic clk = 0, rstN = 0;
  logic wrValid = 0, wrSof = 0, wrEof = 0, acceptRunt = 0, stripEn = 0, rdReady = 0;
  logic [7:0] wrData = 0;
  logic [1:0] wmCode = 2'b01;
  logic rdValid, rdSof, rdEof, dmaReq;
  logic [7:0] rdData;
  logic [13:0] rdStatus;
  int nTests = 0, nFail = 0, cycles = 0;

  always #5 clk = ~clk;

  rx_frame_fifo dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrSof(wrSof),
    .wrEof(wrEof), .acceptRunt(acceptRunt), .stripEn(stripEn), .wmCode(wmCode),
    .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData), .rdSof(rdSof),
    .rdEof(rdEof), .rdStatus(rdStatus), .dmaReq(dmaReq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] genByte(input int seed, input int i, input logic [15:0] lf);
    if (i == 12) return lf[15:8];
    if (i == 13) return lf[7:0];
    return 8'((seed * 7 + i * 13) & 255);
  endfunction

  task automatic putByte(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    wrValid = 1; wrData = d; wrSof = s; wrEof = e;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    wrValid = 0; wrSof = 0; wrEof = 0;
  endtask

  task automatic sendFrame(input int seed, input int n, input logic [15:0] lf, input bit withEof);
    for (int i = 0; i < n; i++) putByte(genByte(seed, i, lf), i == 0, withEof && (i == n - 1));
    idle();
  endtask

  task automatic readBytes(input int seed, input logic [15:0] lf, input int first, input int n,
                           input bit lastEof, input int expStat, input string tag);
    for (int k = 0; k < n; k++) begin
      int idx = first + k;
      int w = 0;
      @(negedge clk);
      rdReady = 0;
      while (!rdValid && w < 50) begin @(negedge clk); w++; end
      chk(rdValid == 1, {tag, " valid"}, rdValid, 1);
      chk(rdData == genByte(seed, idx, lf), {tag, " data"}, rdData, genByte(seed, idx, lf));
      chk(rdSof == (idx == 0), {tag, " sof"}, rdSof, idx == 0);
      chk(rdEof == (lastEof && k == n - 1), {tag, " eof"}, rdEof, lastEof && k == n - 1);
      if (lastEof && k == n - 1) chk(rdStatus == 14'(expStat), {tag, " status"}, rdStatus, expStat);
      rdReady = 1;
      @(posedge clk);
    end
    @(negedge clk);
    rdReady = 0;
  endtask

  task automatic expectEmpty(input string tag);
    repeat (3) @(negedge clk);
    chk(rdValid == 0, {tag, " empty"}, rdValid, 0);
  endtask

  task automatic testReset(); // R1
    chk(rdValid == 0, "R1 rdValid", rdValid, 0);
    chk(dmaReq == 0, "R1 dmaReq", dmaReq, 0);
  endtask

  task automatic testNormal(); // R2
    sendFrame(1, 100, 16'h0800, 1);
    readBytes(1, 16'h0800, 0, 100, 1, 100 << 3, "R2 100B");
    sendFrame(2, 64, 16'h0800, 1);
    readBytes(2, 16'h0800, 0, 64, 1, 64 << 3, "R2 64B");
    expectEmpty("R2");
  endtask

  task automatic testRunt(); // R3
    acceptRunt = 0;
    sendFrame(3, 40, 16'h0800, 1);
    sendFrame(4, 63, 16'h0800, 1);
    sendFrame(5, 70, 16'h0800, 1);
    readBytes(5, 16'h0800, 0, 70, 1, 70 << 3, "R3 after runts");
    expectEmpty("R3");
  endtask

  task automatic testStatFull(); // R4 R5 R10
    acceptRunt = 1;
    for (int f = 0; f < 9; f++) sendFrame(10 + f, 2, 16'h0800, 1);
    @(negedge clk);
    chk(dmaReq == 1, "R5 frame queued", dmaReq, 1);
    for (int f = 0; f < 8; f++) readBytes(10 + f, 16'h0800, 0, 2, 1, (2 << 3) | 2, "R4 runt kept");
    expectEmpty("R10 ninth dropped");
    chk(dmaReq == 0, "R10 dmaReq", dmaReq, 0);
    acceptRunt = 0;
  endtask

  task automatic testWatermark(input logic [1:0] code, input int low); // R5
    wmCode = code;
    sendFrame(30 + code, low, 16'h0800, 0);
    @(negedge clk);
    chk(dmaReq == 0, "R5 below level", dmaReq, 0);
    putByte(genByte(30 + code, low, 16'h0800), 0, 0);
    idle();
    @(negedge clk);
    chk(dmaReq == 1, "R5 at level", dmaReq, 1);
    putByte(genByte(30 + code, low + 1, 16'h0800), 0, 1);
    idle();
    readBytes(30 + code, 16'h0800, 0, low + 2, 1, (low + 2) << 3, "R5 drain");
    wmCode = 2'b01;
  endtask

  task automatic testStrip(); // R6 R7
    stripEn = 1;
    sendFrame(40, 70, 16'd20, 1);
    readBytes(40, 16'd20, 0, 34, 1, (34 << 3) | 1, "R6 len20");
    sendFrame(41, 64, 16'd46, 1);
    readBytes(41, 16'd46, 0, 60, 1, (60 << 3) | 1, "R6 len46");
    sendFrame(42, 80, 16'h0800, 1);
    readBytes(42, 16'h0800, 0, 80, 1, 80 << 3, "R7 type");
    sendFrame(43, 120, 16'd100, 1);
    readBytes(43, 16'd100, 0, 120, 1, 120 << 3, "R7 len100");
    expectEmpty("R6");
    stripEn = 0;
  endtask

  task automatic testOverflow(); // R8
    sendFrame(50, 300, 16'h0800, 1);
    readBytes(50, 16'h0800, 0, 256, 1, (256 << 3) | 4, "R8 overflow");
    expectEmpty("R8");
  endtask

  task automatic testEarly(); // R9
    sendFrame(60, 70, 16'h0800, 0);
    readBytes(60, 16'h0800, 0, 69, 0, 0, "R9 early");
    expectEmpty("R9 hold last");
    putByte(genByte(60, 70, 16'h0800), 0, 1);
    idle();
    readBytes(60, 16'h0800, 69, 2, 1, 71 << 3, "R9 tail");
  endtask

  task automatic testHold(); // R11
    sendFrame(70, 64, 16'h0800, 1);
    @(negedge clk);
    begin
      logic [7:0] d0 = rdData;
      repeat (4) @(negedge clk);
      chk(rdValid == 1 && rdData == d0, "R11 hold", rdData, d0);
    end
    readBytes(70, 16'h0800, 0, 64, 1, 64 << 3, "R11 drain");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testNormal();
    testRunt();
    testStatFull();
    testWatermark(2'b00, 63);
    testWatermark(2'b01, 64);
    testWatermark(2'b10, 128);
    testWatermark(2'b11, 128);
    testStrip();
    testOverflow();
    testEarly();
    testHold();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule